// File: doc/BRIEF.md
# Half-Bridge Gate Command Sequencer

This block converts one pulse-width command into a pair of gate enables for the upper and lower switches of a half-bridge. The switching period and the upper on-interval are both counted in clock cycles. A programmable guard interval is placed between one switch turning off and the other turning on, in both directions. The upper on-interval is limited to a fixed fraction of the period.

After every enable, the lower switch is held on for a fixed number of cycles before the first upper turn-on. This gives the upper driver's floating supply time to charge. Both gates are forced off at once when the bias supply is reported bad or when either shutdown line is active. Any such event returns the sequencer to idle, so the charge phase repeats on the next enable.

Period values outside the legal window are refused. When the two internal requests are ever high together, both gates are turned off. Either event sets a sticky fault flag that only reset clears.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is low and after it is released with shutdown active, `gate_hi_o`, `gate_lo_o` and `fault_o` are all 0.
- R2: In steady switching with period P, effective duty D and guard G, each period holds `gate_hi_o` high for D−G cycles and `gate_lo_o` high for P−D−G cycles. The effective duty D is the duty command after the limit of R6.
- R3: The guard G is `dead_i` clamped to the range DT_MIN..DT_MAX (3..6 by default). Both low-to-high handovers, upper-to-lower and lower-to-upper, leave both gates low for exactly G cycles, and never for fewer than DT_MIN.
- R4: `gate_hi_o` and `gate_lo_o` are never high in the same cycle. If the internal upper and lower requests are both high, both gates go low and `fault_o` is set.
- R5: After each enable, `gate_lo_o` stays high for exactly PRECHARGE_CYC cycles (500 by default) before `gate_hi_o` rises for the first time.
- R6: The effective duty is min(duty, floor(P·CAP_NUM/CAP_DEN)), which is 95 % of the period by default.
- R7: When `bias_ok_i` is 0, `halt_i` is 1 or `halt_n_i` is 0, both gates are 0 on the next clock edge and the sequencer goes idle. Removing the condition restarts the phase of R5.
- R8: A period outside MIN_PERIOD..MAX_PERIOD (16..500 by default) is refused, in two cases. At start the sequencer stays idle. At a period boundary both gates go low. In both cases `fault_o` is set and stays 1 until reset.
- R9: Period, duty and guard are sampled only at a period boundary, so a change of `duty_i` mid-period affects only the next period.
- R10: A duty of 0 keeps `gate_lo_o` continuously high. A duty not above G never raises `gate_hi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Switching period in cycles |
| duty_i | input | CNT_W | Requested upper on-interval in cycles |
| dead_i | input | DT_W | Requested guard interval in cycles |
| bias_ok_i | input | 1 | Gate bias supply within limits |
| halt_i | input | 1 | Shutdown, active high |
| halt_n_i | input | 1 | Shutdown, active low |
| gate_hi_o | output | 1 | Upper switch gate enable (registered) |
| gate_lo_o | output | 1 | Lower switch gate enable (registered) |
| fault_o | output | 1 | Sticky fault: refused period or simultaneous request |

## Verification
The properties assume that the bias and shutdown inputs are synchronous to the clock. The guard property checks only the DT_MIN floor, because the programmed guard may change at each boundary. The on-time property bounds the upper pulse by the cap of the largest legal period, so it holds only while periods stay legal or the sequencer is idle. The stimulus changes every input on falling edges and uses only legal periods, except in the deliberate refusal cases. In those cases both gates are off.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CHARGE = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;
endpackage

// File: rtl/hb_cfg_check.sv
module hb_cfg_check #(
    parameter int CNT_W      = 10,
    parameter int DT_W       = 3,
    parameter int DT_MIN     = 3,
    parameter int DT_MAX     = 6,
    parameter int MIN_PERIOD = 16,
    parameter int MAX_PERIOD = 500,
    parameter int CAP_NUM    = 95,
    parameter int CAP_DEN    = 100
) (
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DT_W-1:0]  dead_i,
    output logic             per_ok_o,
    output logic [CNT_W-1:0] duty_cap_o,
    output logic [DT_W-1:0]  dead_eff_o
);
    localparam int PROD_W = CNT_W + $clog2(CAP_NUM + 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] limit;

    always_comb begin
        per_ok_o = (period_i >= CNT_W'(MIN_PERIOD)) && (period_i <= CNT_W'(MAX_PERIOD));
        // upper on-interval limit: floor(period * num / den)
        prod  = PROD_W'(period_i) * PROD_W'(CAP_NUM);
        limit = prod / PROD_W'(CAP_DEN);
        if (PROD_W'(duty_i) > limit) duty_cap_o = CNT_W'(limit);
        else                         duty_cap_o = duty_i;
        if (dead_i < DT_W'(DT_MIN))      dead_eff_o = DT_W'(DT_MIN);
        else if (dead_i > DT_W'(DT_MAX)) dead_eff_o = DT_W'(DT_MAX);
        else                             dead_eff_o = dead_i;
    end
endmodule

// File: rtl/hb_phase_ctl.sv
module hb_phase_ctl
    import hb_gate_pkg::*;
#(
    parameter int CNT_W         = 10,
    parameter int DT_W          = 3,
    parameter int PRECHARGE_CYC = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             per_ok_i,
    input  logic [CNT_W-1:0] per_in_i,
    input  logic [CNT_W-1:0] duty_in_i,
    input  logic [DT_W-1:0]  dead_in_i,
    input  logic             lo_gate_i,
    output logic             top_req_o,
    output logic             bot_req_o,
    output logic [DT_W-1:0]  dead_o,
    output logic             reject_o
);
    localparam int PRE_W = $clog2(PRECHARGE_CYC + 1);
    // the lower gate register adds one cycle, so leave the phase one early
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRECHARGE_CYC - 2);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic [DT_W-1:0]  dead;
        logic [PRE_W-1:0] pre;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        reject_o = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                ctl_d.cnt = '0;
                ctl_d.pre = '0;
                if (per_ok_i) begin
                    ctl_d.ph   = PH_CHARGE;
                    ctl_d.per  = per_in_i;
                    ctl_d.duty = duty_in_i;
                    ctl_d.dead = dead_in_i;
                end else begin
                    reject_o = 1'b1;
                end
            end
            PH_CHARGE: begin
                if (lo_gate_i) begin
                    if (ctl_q.pre == PRE_LAST) begin
                        ctl_d.ph  = PH_RUN;
                        ctl_d.cnt = '0;
                    end else begin
                        ctl_d.pre = ctl_q.pre + 1'b1;
                    end
                end
            end
            PH_RUN: begin
                if (ctl_q.cnt == ctl_q.per - CNT_W'(1)) begin
                    ctl_d.cnt = '0;
                    if (per_ok_i) begin
                        ctl_d.per  = per_in_i;
                        ctl_d.duty = duty_in_i;
                        ctl_d.dead = dead_in_i;
                    end else begin
                        reject_o = 1'b1;
                        ctl_d.ph = PH_IDLE;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
        if (!en_i) begin
            ctl_d.ph = PH_IDLE;
            reject_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign top_req_o = (ctl_q.ph == PH_RUN) && (ctl_q.cnt < ctl_q.duty);
    assign bot_req_o = (ctl_q.ph == PH_CHARGE) ||
                       ((ctl_q.ph == PH_RUN) && !(ctl_q.cnt < ctl_q.duty));
    assign dead_o    = ctl_q.dead;
endmodule

// File: rtl/hb_dead_gate.sv
module hb_dead_gate #(
    parameter int DT_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kill_i,
    input  logic            top_req_i,
    input  logic            bot_req_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            hi_o,
    output logic            lo_o,
    output logic            lock_o
);
    typedef struct packed {
        logic            hi;
        logic            lo;
        logic [DT_W-1:0] gap;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  gap_done;

    always_comb begin
        gate_d   = gate_q;
        gap_done = (gate_q.gap >= dead_i);
        lock_o   = 1'b0;
        if (kill_i) begin
            gate_d.hi = 1'b0;
            gate_d.lo = 1'b0;
        end else if (top_req_i && bot_req_i) begin
            gate_d.hi = 1'b0;
            gate_d.lo = 1'b0;
            lock_o    = 1'b1;
        end else begin
            gate_d.hi = top_req_i && (gate_q.hi || (!gate_q.lo && gap_done));
            gate_d.lo = bot_req_i && (gate_q.lo || (!gate_q.hi && gap_done));
        end
        // cycles both gates have spent low, saturating
        if (gate_d.hi || gate_d.lo)  gate_d.gap = '0;
        else if (gate_q.gap != '1)   gate_d.gap = gate_q.gap + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign hi_o = gate_q.hi;
    assign lo_o = gate_q.lo;
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
    parameter int CNT_W         = 10,
    parameter int DT_W          = 3,
    parameter int DT_MIN        = 3,
    parameter int DT_MAX        = 6,
    parameter int MIN_PERIOD    = 16,
    parameter int MAX_PERIOD    = 500,
    parameter int PRECHARGE_CYC = 500,
    parameter int CAP_NUM       = 95,
    parameter int CAP_DEN       = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DT_W-1:0]  dead_i,
    input  logic             bias_ok_i,
    input  logic             halt_i,
    input  logic             halt_n_i,
    output logic             gate_hi_o,
    output logic             gate_lo_o,
    output logic             fault_o
);
    logic             en;
    logic             per_ok;
    logic [CNT_W-1:0] duty_cap;
    logic [DT_W-1:0]  dead_eff;
    logic             top_req;
    logic             bot_req;
    logic [DT_W-1:0]  dead_cur;
    logic             reject;
    logic             lock;
    logic             fault_d, fault_q;

    assign en = bias_ok_i && !halt_i && halt_n_i;

    hb_cfg_check #(
        .CNT_W(CNT_W), .DT_W(DT_W), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX),
        .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD),
        .CAP_NUM(CAP_NUM), .CAP_DEN(CAP_DEN)
    ) u_cfg (
        .period_i  (period_i),
        .duty_i    (duty_i),
        .dead_i    (dead_i),
        .per_ok_o  (per_ok),
        .duty_cap_o(duty_cap),
        .dead_eff_o(dead_eff)
    );

    hb_phase_ctl #(
        .CNT_W(CNT_W), .DT_W(DT_W), .PRECHARGE_CYC(PRECHARGE_CYC)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .per_ok_i (per_ok),
        .per_in_i (period_i),
        .duty_in_i(duty_cap),
        .dead_in_i(dead_eff),
        .lo_gate_i(gate_lo_o),
        .top_req_o(top_req),
        .bot_req_o(bot_req),
        .dead_o   (dead_cur),
        .reject_o (reject)
    );

    hb_dead_gate #(
        .DT_W(DT_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill_i   (!en),
        .top_req_i(top_req),
        .bot_req_i(bot_req),
        .dead_i   (dead_cur),
        .hi_o     (gate_hi_o),
        .lo_o     (gate_lo_o),
        .lock_o   (lock)
    );

    always_comb begin
        fault_d = fault_q || reject || lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= fault_d;
        end
    end

    assign fault_o = fault_q;
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
    parameter int DT_MIN     = 3,
    parameter int MAX_PERIOD = 500,
    parameter int CAP_NUM    = 95,
    parameter int CAP_DEN    = 100
) (
    input logic clk,
    input logic rst_n,
    input logic bias_ok_i,
    input logic halt_i,
    input logic halt_n_i,
    input logic gate_hi_o,
    input logic gate_lo_o,
    input logic fault_o
);
    localparam int HI_LIMIT = (MAX_PERIOD * CAP_NUM) / CAP_DEN;

    logic [7:0]  low_run;
    logic [15:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
            hi_run  <= '0;
        end else begin
            if (gate_hi_o || gate_lo_o) low_run <= '0;
            else if (low_run != 8'hFF)  low_run <= low_run + 1'b1;
            if (!gate_hi_o)             hi_run  <= '0;
            else if (hi_run != 16'hFFFF) hi_run <= hi_run + 1'b1;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_o && gate_lo_o)); // R4

    AST_GUARD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi_o) || $rose(gate_lo_o)) |-> (low_run >= 8'(DT_MIN))); // R3

    AST_BLANK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bias_ok_i || halt_i || !halt_n_i) |=> (!gate_hi_o && !gate_lo_o)); // R7

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o); // R8

    AST_HI_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= 16'(HI_LIMIT)); // R6
endmodule

bind hb_gate_seq hb_gate_seq_chk #(
    .DT_MIN(DT_MIN), .MAX_PERIOD(MAX_PERIOD), .CAP_NUM(CAP_NUM), .CAP_DEN(CAP_DEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bias_ok_i(bias_ok_i),
    .halt_i   (halt_i),
    .halt_n_i (halt_n_i),
    .gate_hi_o(gate_hi_o),
    .gate_lo_o(gate_lo_o),
    .fault_o  (fault_o)
);

// File: tb/hb_gate_seq_test.sv
module hb_gate_seq_test;
    localparam int PRE = 500;
    localparam int NV  = 6;
    // period, duty, dead in, expected hi width, expected lo width, expected guard
    localparam int VEC [NV][6] = '{
        '{100,  40, 3,  37, 57, 3},
        '{100, 100, 4,  91,  1, 4},   // R6 cap to 95
        '{ 50,  25, 6,  19, 19, 6},
        '{500, 480, 5, 470, 20, 5},   // R6 cap to 475
        '{ 20,  10, 1,   7,  7, 3},   // R3 clamp up
        '{ 60,  30, 7,  24, 24, 6}    // R3 clamp down
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] period = 10'd100;
    logic [9:0] duty = 10'd40;
    logic [2:0] dead = 3'd3;
    logic       bias_ok = 1'b1;
    logic       halt = 1'b1;
    logic       halt_n = 1'b1;
    logic       hi, lo, fault;

    int checks = 0;
    int errors = 0;
    int overlaps = 0;
    int min_gap = 1000;
    int low_run = 0;

    always #2 clk = ~clk;

    hb_gate_seq uut (
        .clk(clk), .rst_n(rst_n), .period_i(period), .duty_i(duty), .dead_i(dead),
        .bias_ok_i(bias_ok), .halt_i(halt), .halt_n_i(halt_n),
        .gate_hi_o(hi), .gate_lo_o(lo), .fault_o(fault)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (hi && lo) overlaps++;
            if (!hi && !lo) low_run++;
            else begin
                if (low_run > 0 && low_run < min_gap) min_gap = low_run;
                low_run = 0;
            end
        end else begin
            low_run = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit cond(input int sel);
        case (sel)
            0:       return hi;
            1:       return lo;
            default: return !hi && !lo;
        endcase
    endfunction

    task automatic count_while(input int sel, output int n);
        n = 0;
        while (cond(sel) && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_for(input int sel);
        int n = 0;
        while (!cond(sel) && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic restart(input int p, input int d, input int g);
        halt   = 1'b1;
        period = 10'(p);
        duty   = 10'(d);
        dead   = 3'(g);
        tick(4);
        halt = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w;
        int hi_seen;
        // R1 reset state
        tick(3);
        check(!hi && !lo && !fault, "R1", "outputs in reset", {hi, lo, fault}, 0);
        rst_n = 1'b1;
        tick(5);
        check(!hi && !lo && !fault, "R1", "outputs after reset", {hi, lo, fault}, 0);

        // table of vectors: R5 charge, R3 guard, R2 widths
        for (int v = 0; v < NV; v++) begin
            restart(VEC[v][0], VEC[v][1], VEC[v][2]);
            wait_for(1);
            count_while(1, w);
            check(w == PRE, "R5", "charge width", w, PRE);
            count_while(2, w);
            check(w == VEC[v][5], "R3", "guard lo->hi", w, VEC[v][5]);
            count_while(0, w);
            check(w == VEC[v][3], "R2", "hi width", w, VEC[v][3]);
            count_while(2, w);
            check(w == VEC[v][5], "R3", "guard hi->lo", w, VEC[v][5]);
            count_while(1, w);
            check(w == VEC[v][4], "R2", "lo width", w, VEC[v][4]);
        end
        check(fault == 1'b0, "R8", "no fault on legal periods", fault, 0);

        // R9 duty change mid-period is taken at the next boundary
        restart(100, 40, 3);
        wait_for(0);
        duty = 10'd70;
        count_while(0, w);
        check(w == 37, "R9", "hi width old duty", w, 37);
        count_while(2, w);
        count_while(1, w);
        check(w == 57, "R9", "lo width old duty", w, 57);
        count_while(2, w);
        count_while(0, w);
        check(w == 67, "R9", "hi width new duty", w, 67);

        // R7 blanking by each disable input, restart with charge phase
        wait_for(0);
        halt = 1'b1;
        tick(1);
        check(!hi && !lo, "R7", "halt_i blanks", {hi, lo}, 0);
        tick(20);
        check(!hi && !lo, "R7", "halt_i holds off", {hi, lo}, 0);
        halt = 1'b0;
        wait_for(1);
        count_while(1, w);
        check(w == PRE, "R7", "charge after re-enable", w, PRE);
        wait_for(0);
        halt_n = 1'b0;
        tick(1);
        check(!hi && !lo, "R7", "halt_n_i blanks", {hi, lo}, 0);
        halt_n = 1'b1;
        wait_for(1);
        count_while(1, w);
        check(w == PRE, "R7", "charge after halt_n release", w, PRE);
        wait_for(1);
        bias_ok = 1'b0;
        tick(1);
        check(!hi && !lo, "R7", "bias_ok_i low blanks lo", {hi, lo}, 0);
        bias_ok = 1'b1;
        tick(2);

        // R10 zero duty and duty not above guard
        restart(100, 0, 3);
        wait_for(1);
        hi_seen = 0;
        for (int i = 0; i < 700; i++) begin
            if (hi || !lo) hi_seen++;
            tick(1);
        end
        check(hi_seen == 0, "R10", "duty 0 keeps lo on", hi_seen, 0);
        restart(100, 2, 3);
        wait_for(1);
        hi_seen = 0;
        for (int i = 0; i < 900; i++) begin
            if (hi) hi_seen++;
            tick(1);
        end
        check(hi_seen == 0, "R10", "duty below guard keeps hi off", hi_seen, 0);

        // R8 period refusal and sticky fault
        restart(600, 40, 3);
        tick(50);
        check(!hi && !lo, "R8", "long period stays idle", {hi, lo}, 0);
        check(fault == 1'b1, "R8", "fault on long period", fault, 1);
        halt = 1'b1;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(2);
        check(fault == 1'b0, "R8", "reset clears fault", fault, 0);
        restart(10, 4, 3);
        tick(20);
        check(fault == 1'b1 && !hi && !lo, "R8", "short period refused",
              {fault, hi, lo}, 4);
        halt = 1'b1;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        restart(100, 40, 3);
        wait_for(0);
        check(fault == 1'b0, "R8", "fault clear while legal", fault, 0);
        period = 10'd600;
        tick(250);
        check(!hi && !lo, "R8", "refused at boundary", {hi, lo}, 0);
        check(fault == 1'b1, "R8", "fault after boundary refusal", fault, 1);

        // R4 and R3 from the edge monitor
        check(overlaps == 0, "R4", "cycles with both gates high", overlaps, 0);
        check(min_gap >= 3, "R3", "shortest guard seen", min_gap, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule